// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steps a processor core through taking, nesting, chaining and leaving exception handlers. An external arbiter presents its most urgent pending request as a valid flag, an interrupt index and a group priority, where a numerically lower priority is more urgent. The sequencer decides whether that request may enter. If it may, the sequencer drives one-hot strobes that ask the surrounding core to save context, fetch a handler vector or restore context. It waits for a done handshake for each of these steps before it moves on.

The block keeps a stack of the group priorities of the handlers that are active. The top of the stack is the priority that is currently running, and incoming requests are compared against it. When a handler completes and a request already outranks what would be resumed, the sequencer goes straight to the vector fetch and skips both the restore and a fresh save. If a more urgent request appears while context is still being saved, or before the first handler instruction executes, the vector fetch is retargeted to that request and the save is not repeated. The memory traffic and the instruction execution themselves sit outside the block and are seen only through the handshakes.

Top module: `exc_seq`

## Requirements
- R1: After reset the block is in thread mode. No strobe is high, `in_handler` is low, `depth` is 0, `stack_err` is 0 and `active_prio` is the sentinel 2**PRIO_W.
- R2: In thread mode, any valid request starts entry. `save_req` rises the next cycle and holds until `save_done`. After `save_done`, `vec_req` is high with `vec_idx` equal to the captured index.
- R3: A request strictly more urgent than the current target that arrives while `save_req` or `vec_req` is high replaces the target. The save continues unchanged. A `vec_done` in the same cycle as such a replacement is ignored.
- R4: `vec_done` with no replacement enters the handler. The target priority is pushed, so `active_prio` becomes that priority and `depth` grows by one.
- R5: In a handler whose first instruction has not yet executed (`first_exec` not yet seen), a strictly more urgent request abandons that handler. Its priority is popped and `vec_req` follows the next cycle with no save.
- R6: In a handler after `first_exec`, a strictly more urgent request nests. A save comes first, then a vector fetch, and then `depth` grows by one.
- R7: A request whose priority is equal to or less urgent than `active_prio` does not leave the handler.
- R8: On `handler_done`, the top entry is popped. If a valid request is strictly more urgent than the new top, `vec_req` follows the next cycle with no save and no restore.
- R9: On `handler_done` without such a request, `restore_req` holds until `restore_done`. After that the block returns to the handler below, or to thread mode when `depth` is 0.
- R10: A push onto a full stack (DEPTH entries) is dropped, so `depth` stays at DEPTH. A pop from an empty stack is also dropped. Either event sets `stack_err`, which stays set until reset.
- R11: At most one of `save_req`, `vec_req` and `restore_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Arbiter holds a pending request |
| req_idx | input | IDX_W | Index of the pending request |
| req_prio | input | PRIO_W | Group priority of the request, lower is more urgent |
| save_done | input | 1 | Context save finished |
| vec_done | input | 1 | Vector fetch finished |
| first_exec | input | 1 | First handler instruction reached execute |
| handler_done | input | 1 | Running handler completed |
| restore_done | input | 1 | Context restore finished |
| save_req | output | 1 | Context save in progress |
| vec_req | output | 1 | Vector fetch in progress |
| vec_idx | output | IDX_W | Index whose vector is being fetched |
| restore_req | output | 1 | Context restore in progress |
| in_handler | output | 1 | A handler body is running |
| active_prio | output | PRIO_W+1 | Top of priority stack, or sentinel 2**PRIO_W when empty |
| depth | output | $clog2(DEPTH+1) | Number of stacked priorities |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench targets a few specific corner cases.

- It sends a request of equal priority into a running handler. A design that compared with less-or-equal would start a save there.
- It retargets once during the save and again in the same cycle as `vec_done`. A design that let the handshake win would enter the stale handler.
- It completes a handler while a request outranks the one below. A design that checked against the finished handler's priority, or that restored first, would show `restore_req` or `save_req`.
- It preempts a handler before its first instruction. A design that treated this as nesting would save again and leave a stale priority on the stack.
- It nests past the stack depth. A design without the bound would wrap `depth` or lose the sticky flag.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        ST_THREAD  = 3'd0,
        ST_SAVE    = 3'd1,
        ST_VECTOR  = 3'd2,
        ST_HANDLER = 3'd3,
        ST_RESTORE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/exc_prio_stack.sv
module exc_prio_stack #(
    parameter int PRIO_W = 3,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    output logic [PRIO_W:0]   top_prio,
    output logic [PRIO_W:0]   below_prio,
    output logic [CNT_W-1:0]  count,
    output logic              err
);

    localparam logic [PRIO_W:0] SENTINEL = {1'b1, {PRIO_W{1'b0}}};

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CNT_W-1:0]             cnt;
        logic                         err;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            if (s_q.cnt == CNT_W'(DEPTH)) begin
                s_d.err = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.cnt == CNT_W'(i)) s_d.ent[i] = push_prio;
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (pop) begin
            if (s_q.cnt == '0) s_d.err = 1'b1;
            else               s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_comb begin
        top_prio   = SENTINEL;
        below_prio = SENTINEL;
        for (int i = 0; i < DEPTH; i++) begin
            if (s_q.cnt == CNT_W'(i + 1)) top_prio   = {1'b0, s_q.ent[i]};
            if (s_q.cnt == CNT_W'(i + 2)) below_prio = {1'b0, s_q.ent[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign err   = s_q.err;

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              save_done,
    input  logic              vec_done,
    input  logic              first_exec,
    input  logic              handler_done,
    input  logic              restore_done,
    input  logic [PRIO_W:0]   top_prio,
    input  logic [PRIO_W:0]   below_prio,
    input  logic              stack_empty,
    output logic              push,
    output logic              pop,
    output logic [PRIO_W-1:0] push_prio,
    output seq_state_e        state,
    output logic [IDX_W-1:0]  tgt_idx
);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
        logic              started;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [PRIO_W:0] req_ext;
    logic            beats_tgt, beats_top, beats_below;

    always_comb begin
        req_ext     = {1'b0, req_prio};
        beats_tgt   = req_valid && (req_ext < {1'b0, c_q.prio});
        beats_top   = req_valid && (req_ext < top_prio);
        beats_below = req_valid && (req_ext < below_prio);
    end

    always_comb begin
        c_d  = c_q;
        push = 1'b0;
        pop  = 1'b0;
        unique case (c_q.st)
            ST_THREAD: begin
                if (req_valid) begin
                    c_d.idx  = req_idx;
                    c_d.prio = req_prio;
                    c_d.st   = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (beats_tgt) begin
                    c_d.idx  = req_idx;
                    c_d.prio = req_prio;
                end
                if (save_done) c_d.st = ST_VECTOR;
            end
            ST_VECTOR: begin
                if (beats_tgt) begin
                    c_d.idx  = req_idx;
                    c_d.prio = req_prio;
                end else if (vec_done) begin
                    push        = 1'b1;
                    c_d.st      = ST_HANDLER;
                    c_d.started = 1'b0;
                end
            end
            ST_HANDLER: begin
                if (handler_done) begin
                    pop = 1'b1;
                    if (beats_below) begin
                        c_d.idx  = req_idx;
                        c_d.prio = req_prio;
                        c_d.st   = ST_VECTOR;
                    end else begin
                        c_d.st   = ST_RESTORE;
                    end
                end else if (beats_top) begin
                    c_d.idx  = req_idx;
                    c_d.prio = req_prio;
                    if (!c_q.started) begin
                        pop    = 1'b1;
                        c_d.st = ST_VECTOR;
                    end else begin
                        c_d.st = ST_SAVE;
                    end
                end else if (first_exec) begin
                    c_d.started = 1'b1;
                end
            end
            ST_RESTORE: begin
                if (restore_done) begin
                    if (stack_empty) begin
                        c_d.st = ST_THREAD;
                    end else begin
                        c_d.st      = ST_HANDLER;
                        c_d.started = 1'b1;
                    end
                end
            end
            default: c_d.st = ST_THREAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_THREAD, idx: '0, prio: '0, started: 1'b0};
        else        c_q <= c_d;
    end

    assign push_prio = c_q.prio;
    assign state     = c_q.st;
    assign tgt_idx   = c_q.idx;

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int PRIO_W = 3,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              save_done,
    input  logic              vec_done,
    input  logic              first_exec,
    input  logic              handler_done,
    input  logic              restore_done,
    output logic              save_req,
    output logic              vec_req,
    output logic [IDX_W-1:0]  vec_idx,
    output logic              restore_req,
    output logic              in_handler,
    output logic [PRIO_W:0]   active_prio,
    output logic [CNT_W-1:0]  depth,
    output logic              stack_err
);

    logic              push_w, pop_w;
    logic [PRIO_W-1:0] push_prio_w;
    logic [PRIO_W:0]   top_w, below_w;
    seq_state_e        state_w;

    exc_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_w),
        .pop        (pop_w),
        .push_prio  (push_prio_w),
        .top_prio   (top_w),
        .below_prio (below_w),
        .count      (depth),
        .err        (stack_err)
    );

    exc_seq_ctrl #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_idx      (req_idx),
        .req_prio     (req_prio),
        .save_done    (save_done),
        .vec_done     (vec_done),
        .first_exec   (first_exec),
        .handler_done (handler_done),
        .restore_done (restore_done),
        .top_prio     (top_w),
        .below_prio   (below_w),
        .stack_empty  (depth == '0),
        .push         (push_w),
        .pop          (pop_w),
        .push_prio    (push_prio_w),
        .state        (state_w),
        .tgt_idx      (vec_idx)
    );

    assign save_req    = (state_w == ST_SAVE);
    assign vec_req     = (state_w == ST_VECTOR);
    assign restore_req = (state_w == ST_RESTORE);
    assign in_handler  = (state_w == ST_HANDLER);
    assign active_prio = top_w;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             save_done,
    input logic             vec_done,
    input logic             handler_done,
    input logic             restore_done,
    input logic             save_req,
    input logic             vec_req,
    input logic             restore_req,
    input logic             in_handler,
    input logic             stack_err
);

    logic idle_w;
    assign idle_w = !save_req && !vec_req && !restore_req && !in_handler;

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, vec_req, restore_req, in_handler}));

    a_r2_thread_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && req_valid) |=> save_req);

    a_r3_save_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_done) |=> save_req);

    a_r4_enter_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_done && !req_valid) |=> in_handler);

    a_r8_done_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && handler_done) |=> !save_req);

    a_r9_restore_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !restore_done) |=> restore_req);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

endmodule

bind exc_seq exc_seq_chk #(.PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .save_done    (save_done),
    .vec_done     (vec_done),
    .handler_done (handler_done),
    .restore_done (restore_done),
    .save_req     (save_req),
    .vec_req      (vec_req),
    .restore_req  (restore_req),
    .in_handler   (in_handler),
    .stack_err    (stack_err)
);

// File: tb/tb_exc_seq.sv
module tb_exc_seq;

    localparam int IDX_W  = 5;
    localparam int PRIO_W = 3;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int SENT   = 1 << PRIO_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic [PRIO_W-1:0] req_prio = '0;
    logic save_done = 1'b0, vec_done = 1'b0, first_exec = 1'b0;
    logic handler_done = 1'b0, restore_done = 1'b0;
    logic save_req, vec_req, restore_req, in_handler, stack_err;
    logic [IDX_W-1:0] vec_idx;
    logic [PRIO_W:0] active_prio;
    logic [CNT_W-1:0] depth;

    always #5 clk = ~clk;

    exc_seq #(.IDX_W(IDX_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .req_prio(req_prio), .save_done(save_done), .vec_done(vec_done),
        .first_exec(first_exec), .handler_done(handler_done),
        .restore_done(restore_done), .save_req(save_req), .vec_req(vec_req),
        .vec_idx(vec_idx), .restore_req(restore_req), .in_handler(in_handler),
        .active_prio(active_prio), .depth(depth), .stack_err(stack_err)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 thread, 1 save, 2 vector, 3 handler, 4 restore
    int m_st = 0, m_idx = 0, m_prio = 0;
    bit m_started = 1'b0, m_err = 1'b0;
    int m_stk[$];
    string m_tag = "R1";

    function automatic int m_top();
        return (m_stk.size() == 0) ? SENT : m_stk[m_stk.size()-1];
    endfunction

    function automatic int m_below();
        return (m_stk.size() < 2) ? SENT : m_stk[m_stk.size()-2];
    endfunction

    task automatic m_pop();
        if (m_stk.size() == 0) m_err = 1'b1;
        else void'(m_stk.pop_back());
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_prio = 0; m_started = 0; m_err = 0;
            m_stk.delete(); m_tag = "R1";
        end else begin
            int rp;
            bit rv;
            rp = int'(req_prio);
            rv = req_valid;
            case (m_st)
                0: if (rv) begin m_idx = req_idx; m_prio = rp; m_st = 1; m_tag = "R2"; end
                1: begin
                    if (rv && rp < m_prio) begin m_idx = req_idx; m_prio = rp; m_tag = "R3"; end
                    if (save_done) m_st = 2;
                end
                2: begin
                    if (rv && rp < m_prio) begin m_idx = req_idx; m_prio = rp; m_tag = "R3"; end
                    else if (vec_done) begin
                        if (m_stk.size() == DEPTH) begin m_err = 1'b1; m_tag = "R10"; end
                        else begin m_stk.push_back(m_prio); m_tag = "R4"; end
                        m_st = 3; m_started = 0;
                    end
                end
                3: begin
                    if (handler_done) begin
                        int nb;
                        nb = m_below();
                        m_pop();
                        if (rv && rp < nb) begin m_idx = req_idx; m_prio = rp; m_st = 2; m_tag = "R8"; end
                        else begin m_st = 4; m_tag = "R9"; end
                    end else if (rv && rp < m_top()) begin
                        m_idx = req_idx; m_prio = rp;
                        if (!m_started) begin m_pop(); m_st = 2; m_tag = "R5"; end
                        else begin m_st = 1; m_tag = "R6"; end
                    end else begin
                        if (first_exec) m_started = 1;
                        if (rv) m_tag = "R7";
                    end
                end
                4: if (restore_done) begin
                    if (m_stk.size() == 0) m_st = 0;
                    else begin m_st = 3; m_started = 1; end
                    m_tag = "R9";
                end
                default: m_st = 0;
            endcase
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ok;
            ok = (save_req == (m_st == 1)) && (vec_req == (m_st == 2)) &&
                 (restore_req == (m_st == 4)) && (in_handler == (m_st == 3)) &&
                 (int'(active_prio) == m_top()) && (int'(depth) == m_stk.size()) &&
                 (stack_err == m_err) && (!vec_req || int'(vec_idx) == m_idx);
            check(ok, m_tag, {save_req, vec_req, restore_req, in_handler}, m_st);
            check($countones({save_req, vec_req, restore_req}) <= 1, "R11",
                  $countones({save_req, vec_req, restore_req}), 1);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_checks++; n_errs++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); endtask
    task automatic req(input int i, input int p);
        req_valid = 1; req_idx = IDX_W'(i); req_prio = PRIO_W'(p); tick(); req_valid = 0;
    endtask
    task automatic sdone(); save_done = 1; tick(); save_done = 0; endtask
    task automatic vdone(); vec_done = 1; tick(); vec_done = 0; endtask
    task automatic fexec(); first_exec = 1; tick(); first_exec = 0; endtask
    task automatic hdone(); handler_done = 1; tick(); handler_done = 0; endtask
    task automatic rdone(); restore_done = 1; tick(); restore_done = 0; endtask
    task automatic nest(input int i, input int p); req(i, p); sdone(); vdone(); fexec(); endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        check(!save_req && !vec_req && !restore_req && !in_handler, "R1", save_req, 0);
        check(active_prio == SENT && depth == 0 && !stack_err, "R1", active_prio, SENT);

        req(5, 4);
        check(save_req, "R2", save_req, 1);
        tick();
        check(save_req, "R2", save_req, 1);
        sdone();
        check(vec_req && vec_idx == 5, "R2", vec_idx, 5);
        vdone();
        check(in_handler && active_prio == 4 && depth == 1, "R4", active_prio, 4);
        fexec();

        req(7, 4);
        check(in_handler && !save_req, "R7", save_req, 0);
        req(8, 6);
        check(in_handler && !save_req, "R7", save_req, 0);

        req(3, 2);
        check(save_req, "R6", save_req, 1);
        req(9, 1);
        check(save_req, "R3", save_req, 1);
        sdone();
        check(vec_req && vec_idx == 9, "R3", vec_idx, 9);
        req_valid = 1; req_idx = 11; req_prio = 0; vec_done = 1; tick();
        req_valid = 0; vec_done = 0;
        check(vec_req && vec_idx == 11, "R3", vec_idx, 11);
        vdone();
        check(in_handler && active_prio == 0 && depth == 2, "R6", depth, 2);
        fexec();

        req_valid = 1; req_idx = 3; req_prio = 2; handler_done = 1; tick();
        req_valid = 0; handler_done = 0;
        check(vec_req && !restore_req && !save_req && vec_idx == 3, "R8", vec_idx, 3);
        check(depth == 1, "R8", depth, 1);
        vdone();
        check(active_prio == 2 && depth == 2, "R8", active_prio, 2);

        req(12, 1);
        check(vec_req && !save_req && vec_idx == 12 && depth == 1, "R5", vec_idx, 12);
        vdone();
        check(active_prio == 1 && depth == 2, "R5", active_prio, 1);
        fexec();

        hdone();
        check(restore_req && active_prio == 4 && depth == 1, "R9", active_prio, 4);
        tick();
        check(restore_req, "R9", restore_req, 1);
        rdone();
        check(in_handler, "R9", in_handler, 1);
        hdone(); rdone();
        check(!in_handler && depth == 0 && active_prio == SENT, "R9", depth, 0);

        nest(1, 6); nest(2, 5); nest(3, 4); nest(4, 3);
        check(depth == DEPTH && !stack_err, "R10", depth, DEPTH);
        nest(5, 2);
        check(depth == DEPTH && stack_err && active_prio == 3, "R10", stack_err, 1);
        for (int k = 0; k < DEPTH; k++) begin hdone(); rdone(); end
        check(!in_handler && depth == 0 && stack_err, "R10", stack_err, 1);
        req(6, 5);
        check(save_req && stack_err, "R10", stack_err, 1);
        sdone(); vdone();

        tick();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule